// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control

This block holds the interlock and forwarding decisions for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the register specifiers and the load, store, write-valid and mispredict flags held in the inter-stage latches. From these it drives the write enables of the program-counter and fetch/decode latches, the clears of the fetch/decode and decode/execute latches, and a bubble request into decode/execute. It also drives the select codes for the execute-stage operand muxes and for the store-data mux in the memory stage.

The operand and store-data selects are worked out one stage early, while the consumer is still in decode, and registered. They are stable from the start of the cycle in which the consumer uses them. The stall and flush controls are combinational, because they must act on the latches in the same cycle that the hazard is seen. A parameter selects a shared instruction/data memory port, which adds a fetch stall whenever a memory operation sits in decode/execute.

Top module: `hazard_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, `alu_a_sel`, `alu_b_sel` and `st_data_sel` are 0 after that edge.
- R2: At each edge that is not killed (see R8), each operand select is loaded with the code for the instruction in fetch/decode. The code is 2 if its nonzero source equals the nonzero `dx_rd` with `dx_wen` set. Otherwise it is 1 if that source equals `xm_rd` with `xm_wen` set. Otherwise it is 0. Source 1 drives `alu_a_sel` and source 2 drives `alu_b_sel`.
- R3: Register 0 never causes a forward or a stall. A destination whose write-valid bit is clear never causes a forward or a stall.
- R4: A load in decode/execute (`dx_is_load`, `dx_wen`, nonzero `dx_rd`) whose destination equals `fd_rs1` stalls for that cycle. It also stalls when it equals `fd_rs2` and `fd_is_store` is 0. A stall drives `pc_we`=0, `fd_we`=0, `dx_bubble`=1 and `fd_clr`=0. The data register of a store is exempt from this stall.
- R5: After each edge not under reset, `st_data_sel` is 1 exactly when, before that edge, `dx_is_store` was set, `dx_rs2` was nonzero, and `dx_rs2` equalled `xm_rd` with `xm_wen` set.
- R6: When `mispredict` is 1, `fd_clr`=1, `dx_clr`=1, `pc_we`=1, `fd_we`=1 and `dx_bubble`=0. This holds whatever stall condition is present.
- R7: With `SHARED_PORT`=1, no mispredict and no load-use stall, a load or store in decode/execute drives `pc_we`=0, `fd_we`=1, `fd_clr`=1 and `dx_bubble`=0.
- R8: After an edge at which `dx_bubble` or `dx_clr` was 1, both operand selects are 0.
- R9: With no mispredict, no load-use stall and no structural stall, `pc_we`=1, `fd_we`=1, and `fd_clr`, `dx_bubble` and `dx_clr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fd_rs1 | input | REG_W | First source specifier in fetch/decode |
| fd_rs2 | input | REG_W | Second source specifier in fetch/decode |
| fd_is_store | input | 1 | Fetch/decode holds a store (its second source is store data) |
| dx_rd | input | REG_W | Destination in decode/execute |
| dx_wen | input | 1 | Decode/execute instruction writes a register |
| dx_is_load | input | 1 | Decode/execute holds a load |
| dx_is_store | input | 1 | Decode/execute holds a store |
| dx_rs2 | input | REG_W | Store-data register in decode/execute |
| xm_rd | input | REG_W | Destination in execute/memory |
| xm_wen | input | 1 | Execute/memory instruction writes a register |
| mispredict | input | 1 | Branch in execute resolved against its prediction |
| pc_we | output | 1 | Program-counter write enable |
| fd_we | output | 1 | Fetch/decode latch write enable |
| fd_clr | output | 1 | Load a nop into fetch/decode |
| dx_bubble | output | 1 | Load a nop into decode/execute because of a stall |
| dx_clr | output | 1 | Load a nop into decode/execute because of a flush |
| alu_a_sel | output | 2 | Operand A mux code: 0 register file, 1 writeback, 2 memory stage |
| alu_b_sel | output | 2 | Operand B mux code, same encoding |
| st_data_sel | output | 1 | Store-data mux: 1 takes the writeback-stage result |

## Verification
The assertions assume that the latch fields are consistent: a bubble or store presents a cleared write-valid bit, and `dx_is_load` and `dx_is_store` are never both set. They also assume that `mispredict` comes only from a live branch. The stimulus table keeps to these combinations: stores always carry `dx_wen`=0, loads always carry `dx_wen`=1, and no row sets both memory flags. The registered selects are checked one edge after the inputs that produce them. This matches the pre-decode timing, in which the consumer's select is fixed while it is still in decode.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
  import hz_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dx_rd,
  input  logic             dx_wen,
  input  logic [REG_W-1:0] xm_rd,
  input  logic             xm_wen,
  output fwd_sel_e         sel
);
  logic src_live;
  assign src_live = (src != '0);

  // The producer now in D/X reaches X/M when the consumer reaches X,
  // so it is the nearer one and wins.
  always_comb begin
    if (src_live && dx_wen && (dx_rd == src))
      sel = FWD_MEM;
    else if (src_live && xm_wen && (xm_rd == src))
      sel = FWD_WB;
    else
      sel = FWD_RF;
  end
endmodule

// File: rtl/hz_wm_match.sv
module hz_wm_match #(
  parameter int REG_W = 5
) (
  input  logic             dx_is_store,
  input  logic [REG_W-1:0] dx_rs2,
  input  logic [REG_W-1:0] xm_rd,
  input  logic             xm_wen,
  output logic             wm_hit
);
  // The store in D/X meets the X/M producer again one stage later,
  // as M against W.
  assign wm_hit = dx_is_store && (dx_rs2 != '0) && xm_wen && (xm_rd == dx_rs2);
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int REG_W       = 5,
  parameter bit SHARED_PORT = 1'b0
) (
  input  logic [REG_W-1:0] fd_rs1,
  input  logic [REG_W-1:0] fd_rs2,
  input  logic             fd_is_store,
  input  logic [REG_W-1:0] dx_rd,
  input  logic             dx_wen,
  input  logic             dx_is_load,
  input  logic             dx_is_store,
  input  logic             mispredict,
  output logic             pc_we,
  output logic             fd_we,
  output logic             fd_clr,
  output logic             dx_bubble,
  output logic             dx_clr
);
  logic load_dst_live;
  logic hit_rs1;
  logic hit_rs2;
  logic load_use;
  logic port_busy;

  assign load_dst_live = dx_is_load && dx_wen && (dx_rd != '0);
  assign hit_rs1       = (fd_rs1 == dx_rd);
  // Store data is forwarded later in M, so it does not hold decode.
  assign hit_rs2       = !fd_is_store && (fd_rs2 == dx_rd);
  assign load_use      = load_dst_live && (hit_rs1 || hit_rs2);
  assign port_busy     = SHARED_PORT && (dx_is_load || dx_is_store);

  always_comb begin
    pc_we     = 1'b1;
    fd_we     = 1'b1;
    fd_clr    = 1'b0;
    dx_bubble = 1'b0;
    dx_clr    = 1'b0;
    if (mispredict) begin
      fd_clr = 1'b1;
      dx_clr = 1'b1;
    end else if (load_use) begin
      pc_we     = 1'b0;
      fd_we     = 1'b0;
      dx_bubble = 1'b1;
    end else if (port_busy) begin
      pc_we  = 1'b0;
      fd_clr = 1'b1;
    end
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_W       = 5,
  parameter bit SHARED_PORT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] fd_rs1,
  input  logic [REG_W-1:0] fd_rs2,
  input  logic             fd_is_store,
  input  logic [REG_W-1:0] dx_rd,
  input  logic             dx_wen,
  input  logic             dx_is_load,
  input  logic             dx_is_store,
  input  logic [REG_W-1:0] dx_rs2,
  input  logic [REG_W-1:0] xm_rd,
  input  logic             xm_wen,
  input  logic             mispredict,
  output logic             pc_we,
  output logic             fd_we,
  output logic             fd_clr,
  output logic             dx_bubble,
  output logic             dx_clr,
  output logic [1:0]       alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             st_data_sel
);
  localparam int NSRC = 2;

  logic [REG_W-1:0] srcs [NSRC];
  fwd_sel_e         nxt  [NSRC];
  fwd_sel_e         sel_q [NSRC];
  logic             wm_hit;
  logic             wm_q;
  logic             kill;

  assign srcs[0] = fd_rs1;
  assign srcs[1] = fd_rs2;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    hz_src_fwd #(.REG_W(REG_W)) u_fwd (
      .src   (srcs[s]),
      .dx_rd (dx_rd),
      .dx_wen(dx_wen),
      .xm_rd (xm_rd),
      .xm_wen(xm_wen),
      .sel   (nxt[s])
    );
  end

  hz_wm_match #(.REG_W(REG_W)) u_wm (
    .dx_is_store(dx_is_store),
    .dx_rs2     (dx_rs2),
    .xm_rd      (xm_rd),
    .xm_wen     (xm_wen),
    .wm_hit     (wm_hit)
  );

  hz_interlock #(.REG_W(REG_W), .SHARED_PORT(SHARED_PORT)) u_lock (
    .fd_rs1     (fd_rs1),
    .fd_rs2     (fd_rs2),
    .fd_is_store(fd_is_store),
    .dx_rd      (dx_rd),
    .dx_wen     (dx_wen),
    .dx_is_load (dx_is_load),
    .dx_is_store(dx_is_store),
    .mispredict (mispredict),
    .pc_we      (pc_we),
    .fd_we      (fd_we),
    .fd_clr     (fd_clr),
    .dx_bubble  (dx_bubble),
    .dx_clr     (dx_clr)
  );

  // A nop enters D/X: nothing for X to forward next cycle.
  assign kill = dx_bubble || dx_clr;

  for (genvar s = 0; s < NSRC; s++) begin : g_selreg
    always_ff @(posedge clk) begin
      if (rst)       sel_q[s] <= FWD_RF;
      else if (kill) sel_q[s] <= FWD_RF;
      else           sel_q[s] <= nxt[s];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wm_q <= 1'b0;
    else     wm_q <= wm_hit;
  end

  assign alu_a_sel   = sel_q[0];
  assign alu_b_sel   = sel_q[1];
  assign st_data_sel = wm_q;
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] fd_rs1,
  input logic             mispredict,
  input logic             pc_we,
  input logic             fd_we,
  input logic             fd_clr,
  input logic             dx_bubble,
  input logic             dx_clr,
  input logic [1:0]       alu_a_sel,
  input logic [1:0]       alu_b_sel,
  input logic             st_data_sel
);
  // R1
  reset_sel_chk: assert property (@(posedge clk)
    rst |=> (alu_a_sel == 2'd0 && alu_b_sel == 2'd0 && !st_data_sel));

  // R2
  sel_code_chk: assert property (@(posedge clk) disable iff (rst)
    alu_a_sel != 2'd3 && alu_b_sel != 2'd3);

  // R3
  zero_src_chk: assert property (@(posedge clk) disable iff (rst)
    (fd_rs1 == '0) |=> alu_a_sel == 2'd0);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dx_bubble |-> (!pc_we && !fd_we && !fd_clr && !dx_clr));

  // R6
  flush_wins_chk: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> (fd_clr && dx_clr && pc_we && fd_we && !dx_bubble));

  // R7
  port_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (fd_clr && !mispredict) |-> (!pc_we && fd_we && !dx_bubble));

  // R8
  kill_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (dx_bubble || dx_clr) |=> (alu_a_sel == 2'd0 && alu_b_sel == 2'd0));

  // R9
  advance_chk: assert property (@(posedge clk) disable iff (rst)
    (!mispredict && !dx_bubble && !fd_clr) |-> (pc_we && fd_we && !dx_clr));
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] fd_rs1 = '0, fd_rs2 = '0, dx_rd = '0, dx_rs2 = '0, xm_rd = '0;
  logic fd_is_store = 0, dx_wen = 0, dx_is_load = 0, dx_is_store = 0, xm_wen = 0, mispredict = 0;
  logic pc_we, fd_we, fd_clr, dx_bubble, dx_clr, st_data_sel;
  logic [1:0] alu_a_sel, alu_b_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hazard_ctrl #(.REG_W(RW), .SHARED_PORT(1'b1)) i_hazard_ctrl (
    .clk(clk), .rst(rst), .fd_rs1(fd_rs1), .fd_rs2(fd_rs2), .fd_is_store(fd_is_store),
    .dx_rd(dx_rd), .dx_wen(dx_wen), .dx_is_load(dx_is_load), .dx_is_store(dx_is_store),
    .dx_rs2(dx_rs2), .xm_rd(xm_rd), .xm_wen(xm_wen), .mispredict(mispredict),
    .pc_we(pc_we), .fd_we(fd_we), .fd_clr(fd_clr), .dx_bubble(dx_bubble), .dx_clr(dx_clr),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .st_data_sel(st_data_sel)
  );

  typedef struct packed {
    logic [3:0]    req;
    logic [RW-1:0] fs1, fs2;
    logic          fst;
    logic [RW-1:0] drd;
    logic          dwen, dld, dst;
    logic [RW-1:0] drs2, xrd;
    logic          xwen, mis;
    logic [4:0]    ctl;   // pc_we, fd_we, fd_clr, dx_bubble, dx_clr
    logic [1:0]    ea, eb;
    logic          est;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd9, 5'd1, 5'd2, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0, 5'd0, 5'd4, 1'b1, 1'b0, 5'b11000, 2'd0, 2'd0, 1'b0}, // R9 idle
    '{4'd2, 5'd3, 5'd4, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0, 5'd0, 5'd4, 1'b1, 1'b0, 5'b11000, 2'd2, 2'd1, 1'b0}, // R2 MX and WX
    '{4'd2, 5'd5, 5'd5, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0, 5'd0, 5'd5, 1'b1, 1'b0, 5'b11000, 2'd2, 2'd2, 1'b0}, // R2 priority
    '{4'd2, 5'd6, 5'd0, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0, 5'd0, 5'd6, 1'b1, 1'b0, 5'b11000, 2'd1, 2'd0, 1'b0}, // R2 WX only
    '{4'd3, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 1'b1, 1'b0, 5'b11000, 2'd0, 2'd0, 1'b0}, // R3 reg 0
    '{4'd3, 5'd3, 5'd4, 1'b0, 5'd3, 1'b0, 1'b0, 1'b0, 5'd0, 5'd4, 1'b0, 1'b0, 5'b11000, 2'd0, 2'd0, 1'b0}, // R3 no write
    '{4'd4, 5'd7, 5'd1, 1'b0, 5'd7, 1'b1, 1'b1, 1'b0, 5'd0, 5'd1, 1'b1, 1'b0, 5'b00010, 2'd0, 2'd0, 1'b0}, // R4 load-use, R8
    '{4'd4, 5'd7, 5'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 5'd7, 1'b1, 1'b0, 5'b11000, 2'd1, 2'd0, 1'b0}, // R4 then WX
    '{4'd4, 5'd2, 5'd7, 1'b1, 5'd7, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'b01100, 2'd0, 2'd2, 1'b0}, // R4 store data exempt
    '{4'd4, 5'd7, 5'd1, 1'b1, 5'd7, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'b00010, 2'd0, 2'd0, 1'b0}, // R4 store address
    '{4'd5, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd9, 5'd9, 1'b1, 1'b0, 5'b01100, 2'd0, 2'd0, 1'b1}, // R5 WM hit
    '{4'd5, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, 1'b1, 1'b0, 5'b01100, 2'd0, 2'd0, 1'b0}, // R5 reg 0
    '{4'd5, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd9, 5'd9, 1'b0, 1'b0, 5'b01100, 2'd0, 2'd0, 1'b0}, // R5 no write
    '{4'd6, 5'd7, 5'd0, 1'b0, 5'd7, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 5'b11101, 2'd0, 2'd0, 1'b0}, // R6 over stall
    '{4'd6, 5'd3, 5'd0, 1'b0, 5'd3, 1'b1, 1'b0, 1'b0, 5'd0, 5'd0, 1'b0, 1'b1, 5'b11101, 2'd0, 2'd0, 1'b0}, // R6 flush, R8
    '{4'd7, 5'd1, 5'd2, 1'b0, 5'd8, 1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'b01100, 2'd0, 2'd0, 1'b0}  // R7 port busy
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    fd_rs1 = v.fs1; fd_rs2 = v.fs2; fd_is_store = v.fst;
    dx_rd = v.drd; dx_wen = v.dwen; dx_is_load = v.dld; dx_is_store = v.dst; dx_rs2 = v.drs2;
    xm_rd = v.xrd; xm_wen = v.xwen; mispredict = v.mis;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    // R1: reset clears selects even with a forwarding pattern present
    apply(VECS[1]);
    repeat (2) @(posedge clk);
    #2;
    check("R1 reset sels", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b0);

    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      apply(VECS[i]);
      #2;
      check($sformatf("R%0d vec %0d controls", VECS[i].req, i),
            {pc_we, fd_we, fd_clr, dx_bubble, dx_clr}, VECS[i].ctl);
      @(posedge clk);
      #2;
      check($sformatf("R%0d vec %0d selects", VECS[i].req, i),
            {alu_a_sel, alu_b_sel, st_data_sel}, {VECS[i].ea, VECS[i].eb, VECS[i].est});
    end

    // R2 then R1: a live select is cleared by reset
    @(negedge clk);
    apply(VECS[2]);
    @(posedge clk); #2;
    check("R2 before reset", {alu_a_sel, alu_b_sel}, 4'b1010);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #2;
    check("R1 mid-run reset", {alu_a_sel, alu_b_sel, st_data_sel}, 5'b0);

    // R9: quiet latches after reset release
    @(negedge clk);
    rst = 1'b0;
    apply('0);
    #2;
    check("R9 quiet controls", {pc_we, fd_we, fd_clr, dx_bubble, dx_clr}, 5'b11000);

    // R8: bubble with a second pending forward still zeroes the selects
    @(negedge clk);
    fd_rs1 = 5'd4; fd_rs2 = 5'd6; dx_rd = 5'd4; dx_wen = 1; dx_is_load = 1; xm_rd = 5'd6; xm_wen = 1;
    @(posedge clk); #2;
    check("R8 bubble clears sels", {alu_a_sel, alu_b_sel}, 4'b0);

    done = 1;
    finish_run();
  end
endmodule